// File: doc/BRIEF.md
# Depth-Tested Blending Raster Operation Unit

This block is the last stage of a fragment pipeline. Each shaded fragment carries a pixel coordinate, a depth value and an 8-bit-per-channel RGBA colour. For every fragment the unit reads the depth stored for that pixel and keeps the fragment only when it lies strictly nearer. A kept fragment replaces the stored depth. Its colour then either overwrites the stored colour or is mixed into it by a read-modify-write, weighted by the fragment's own alpha. A fragment that fails the test leaves both stores untouched.

The depth store and the colour store are internal synchronous RAMs with one entry per pixel, sized by the coordinate width parameters. Fragments arrive on a valid/ready stream, one per cycle. A fragment that targets the pixel still being written by its predecessor is held back, so updates to one pixel always happen in arrival order. A clear command walks every entry, setting the depth to its largest value and the colour to a supplied value. A lookup port reads back the stored depth and colour of any pixel.

Top module: `zrop_unit`

## Requirements
- R1: After reset `frag_ready` is 1 and `clear_busy` is 0.
- R2: A fragment whose depth is strictly smaller than the stored depth writes its depth into the depth store for its pixel.
- R3: A fragment whose depth is equal to or greater than the stored depth is dropped: neither the depth nor the colour of that pixel changes.
- R4: With `frag_blend` = 0, a kept fragment writes its RGBA value unchanged into the colour store.
- R5: With `frag_blend` = 1, each colour channel of a kept fragment becomes round((a·S + (255−a)·D) / 255), where a is the fragment alpha, S the fragment channel and D the stored channel. Packing is red in bits 7:0, green in 15:8, blue in 23:16 and alpha in 31:24.
- R6: Under blending, alpha = 255 stores the fragment colour exactly and alpha = 0 keeps the stored red, green and blue exactly.
- R7: Under blending, the stored alpha becomes the fragment alpha.
- R8: A fragment to the same pixel as the fragment accepted in the previous cycle sees `frag_ready` low for exactly one cycle. The second update is applied on top of the first.
- R9: A `clear_req` pulse makes `clear_busy` high for 2^(X_W+Y_W) cycles, starting one edge later. `frag_ready` stays low throughout. Afterwards every depth holds all ones and every colour holds the `clear_rgba` value sampled with the request.
- R10: The lookup port returns the depth and colour stored at (`look_x`, `look_y`) one clock edge after the address is applied.
- R11: Fragments to different pixels in consecutive cycles are accepted without stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frag_valid | input | 1 | Fragment presented |
| frag_ready | output | 1 | Fragment accepted on this edge when valid |
| frag_x | input | X_W | Fragment column |
| frag_y | input | Y_W | Fragment row |
| frag_z | input | Z_W | Fragment depth, smaller is nearer |
| frag_rgba | input | 32 | Fragment colour {a,b,g,r} |
| frag_blend | input | 1 | 1 = alpha-mix into stored colour, 0 = overwrite |
| clear_req | input | 1 | Start a clear of both stores |
| clear_rgba | input | 32 | Colour written by the clear |
| clear_busy | output | 1 | Clear in progress |
| look_x | input | X_W | Lookup column |
| look_y | input | Y_W | Lookup row |
| look_z | output | Z_W | Stored depth at lookup pixel |
| look_rgba | output | 32 | Stored colour at lookup pixel |

## Verification
A fragment accepted at edge e reads the stores at e, is written at e+1, and is first visible on the lookup port after a lookup address sampled at e+2. The bench therefore waits two idle cycles after the final fragment of a sweep before reading every pixel back, one address per cycle, and samples each result at the falling edge after the address edge. `frag_ready` is combinational on the current input and pipeline state, so stalls are counted at the falling edge before each accepting edge. `clear_busy` is counted the same way, starting at the falling edge after the request edge.

// File: rtl/zrop_pkg.sv
`timescale 1ns/1ps
package zrop_pkg;

   typedef struct packed {
      logic [7:0] a;
      logic [7:0] b;
      logic [7:0] g;
      logic [7:0] r;
   } rgba8_t;

   localparam int CH_W    = 8;
   localparam int RGB_W   = 3 * CH_W;
   localparam int PROD_W  = 2 * CH_W + 1;

   // round(x / 255) for x in [0, 255*255], exact via add-and-shift
   function automatic logic [CH_W-1:0] div255_round(input logic [PROD_W-1:0] x);
      logic [PROD_W-1:0] t;
      t = x + PROD_W'(128);
      t = t + (t >> CH_W);
      return CH_W'(t >> CH_W);
   endfunction

endpackage

// File: rtl/zrop_ram.sv
`timescale 1ns/1ps
module zrop_ram #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int RA_W   = DATA_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] ra_addr,
   output logic [RA_W-1:0]   ra_data,
   input  logic [ADDR_W-1:0] rb_addr,
   output logic [DATA_W-1:0] rb_data
);
   localparam int DEPTH = 1 << ADDR_W;

   if (RA_W < 1 || RA_W > DATA_W) begin : g_bad_ra
      $error("zrop_ram: RA_W must lie in 1..DATA_W");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      ra_data <= mem[ra_addr][RA_W-1:0];
      rb_data <= mem[rb_addr];
   end
endmodule

// File: rtl/zrop_mix.sv
`timescale 1ns/1ps
module zrop_mix
   import zrop_pkg::*;
(
   input  rgba8_t            src,
   input  logic [RGB_W-1:0]  dst_rgb,
   input  logic              en,
   output rgba8_t            res
);
   logic [RGB_W-1:0] rgb_o;

   for (genvar c = 0; c < 3; c++) begin : g_ch
      logic [CH_W-1:0]   s_ch;
      logic [CH_W-1:0]   d_ch;
      logic [CH_W-1:0]   inv_a;
      logic [PROD_W-1:0] acc;

      assign s_ch  = src[CH_W*c +: CH_W];
      assign d_ch  = dst_rgb[CH_W*c +: CH_W];
      assign inv_a = 8'd255 - src.a;
      assign acc   = PROD_W'(src.a) * PROD_W'(s_ch) + PROD_W'(inv_a) * PROD_W'(d_ch);
      assign rgb_o[CH_W*c +: CH_W] = en ? div255_round(acc) : s_ch;
   end

   assign res = {src.a, rgb_o};
endmodule

// File: rtl/zrop_sweep.sv
`timescale 1ns/1ps
module zrop_sweep #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              hold,
   output logic              active,
   output logic              we,
   output logic [ADDR_W-1:0] addr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         addr   <= '0;
      end else if (!active) begin
         if (start) begin
            active <= 1'b1;
            addr   <= '0;
         end
      end else if (!hold) begin
         if (&addr) active <= 1'b0;
         else       addr   <= addr + 1'b1;
      end
   end

   assign we = active && !hold;
endmodule

// File: rtl/zrop_unit.sv
`timescale 1ns/1ps
module zrop_unit
   import zrop_pkg::*;
#(
   parameter int X_W = 4,
   parameter int Y_W = 4,
   parameter int Z_W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           frag_valid,
   output logic           frag_ready,
   input  logic [X_W-1:0] frag_x,
   input  logic [Y_W-1:0] frag_y,
   input  logic [Z_W-1:0] frag_z,
   input  logic [31:0]    frag_rgba,
   input  logic           frag_blend,
   input  logic           clear_req,
   input  logic [31:0]    clear_rgba,
   output logic           clear_busy,
   input  logic [X_W-1:0] look_x,
   input  logic [Y_W-1:0] look_y,
   output logic [Z_W-1:0] look_z,
   output logic [31:0]    look_rgba
);
   localparam int ADDR_W          = X_W + Y_W;
   localparam logic [Z_W-1:0] ZMAX = {Z_W{1'b1}};

   if (X_W < 1 || Y_W < 1) begin : g_bad_dims
      $error("zrop_unit: coordinate widths must be positive");
   end
   if (ADDR_W > 12) begin : g_bad_size
      $error("zrop_unit: pixel count limited to 4096");
   end
   if (Z_W < 2) begin : g_bad_z
      $error("zrop_unit: depth width must be at least 2");
   end

   logic [ADDR_W-1:0] in_addr;
   logic              hazard;
   logic              take;

   logic              s1_vld;
   logic [ADDR_W-1:0] s1_addr;
   logic [Z_W-1:0]    s1_z;
   rgba8_t            s1_rgba;
   logic              s1_blend;

   logic [Z_W-1:0]    st_z;
   logic [RGB_W-1:0]  st_rgb;
   rgba8_t            mix_rgba;
   logic              z_pass;

   logic              clr_active;
   logic              clr_we;
   logic [ADDR_W-1:0] clr_addr;
   logic [31:0]       clr_col;

   logic              mem_we;
   logic [ADDR_W-1:0] w_addr;
   logic [Z_W-1:0]    w_z;
   logic [31:0]       w_rgba;

   // intake and same-pixel hold
   assign in_addr    = {frag_y, frag_x};
   assign hazard     = s1_vld && (s1_addr == in_addr);
   assign frag_ready = !clr_active && !hazard;
   assign take       = frag_valid && frag_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) s1_vld <= 1'b0;
      else        s1_vld <= take;
   end

   always_ff @(posedge clk) begin
      if (take) begin
         s1_addr  <= in_addr;
         s1_z     <= frag_z;
         s1_rgba  <= rgba8_t'(frag_rgba);
         s1_blend <= frag_blend;
      end
   end

   // clear sequencing
   always_ff @(posedge clk) begin
      if (!rst_n)                         clr_col <= '0;
      else if (clear_req && !clr_active)  clr_col <= clear_rgba;
   end

   zrop_sweep #(.ADDR_W(ADDR_W)) u_sweep (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (clear_req),
      .hold   (s1_vld),
      .active (clr_active),
      .we     (clr_we),
      .addr   (clr_addr)
   );

   assign clear_busy = clr_active;

   // depth test and colour mix on the read data
   assign z_pass = s1_z < st_z;

   zrop_mix u_mix (
      .src     (s1_rgba),
      .dst_rgb (st_rgb),
      .en      (s1_blend),
      .res     (mix_rgba)
   );

   assign mem_we = clr_we || (s1_vld && z_pass);
   assign w_addr = clr_we ? clr_addr : s1_addr;
   assign w_z    = clr_we ? ZMAX     : s1_z;
   assign w_rgba = clr_we ? clr_col  : mix_rgba;

   zrop_ram #(.DATA_W(Z_W), .ADDR_W(ADDR_W), .RA_W(Z_W)) u_zmem (
      .clk     (clk),
      .we      (mem_we),
      .waddr   (w_addr),
      .wdata   (w_z),
      .ra_addr (in_addr),
      .ra_data (st_z),
      .rb_addr ({look_y, look_x}),
      .rb_data (look_z)
   );

   zrop_ram #(.DATA_W(32), .ADDR_W(ADDR_W), .RA_W(RGB_W)) u_cmem (
      .clk     (clk),
      .we      (mem_we),
      .waddr   (w_addr),
      .wdata   (w_rgba),
      .ra_addr (in_addr),
      .ra_data (st_rgb),
      .rb_addr ({look_y, look_x}),
      .rb_data (look_rgba)
   );
endmodule

// File: rtl/zrop_chk.sv
`timescale 1ns/1ps
module zrop_chk #(
   parameter int ADDR_W = 8,
   parameter int Z_W    = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frag_valid,
   input logic              frag_ready,
   input logic              busy,
   input logic              s1_vld,
   input logic [ADDR_W-1:0] in_addr,
   input logic [ADDR_W-1:0] s1_addr,
   input logic [Z_W-1:0]    s1_z,
   input logic [Z_W-1:0]    st_z,
   input logic              mem_we,
   input logic              clr_we,
   input logic [Z_W-1:0]    w_z,
   input logic [31:0]       w_rgba,
   input logic [31:0]       s1_rgba,
   input logic [31:0]       clr_col
);
   a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !frag_ready);

   a_r8_same_pixel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (frag_valid && s1_vld && in_addr == s1_addr) |-> !frag_ready);

   a_r3_write_needs_front: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !clr_we) |-> (w_z < st_z));

   a_r2_front_written: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && s1_z < st_z) |-> (mem_we && w_z == s1_z));

   a_r9_clear_fill: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |-> (w_z == {Z_W{1'b1}} && w_rgba == clr_col && !s1_vld));

   a_r6_opaque_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !clr_we && s1_rgba[31:24] == 8'hFF) |-> (w_rgba == s1_rgba));

   a_r7_alpha_from_src: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !clr_we) |-> (w_rgba[31:24] == s1_rgba[31:24]));
endmodule

bind zrop_unit zrop_chk #(.ADDR_W(ADDR_W), .Z_W(Z_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frag_valid (frag_valid),
   .frag_ready (frag_ready),
   .busy       (clear_busy),
   .s1_vld     (s1_vld),
   .in_addr    (in_addr),
   .s1_addr    (s1_addr),
   .s1_z       (s1_z),
   .st_z       (st_z),
   .mem_we     (mem_we),
   .clr_we     (clr_we),
   .w_z        (w_z),
   .w_rgba     (w_rgba),
   .s1_rgba    (s1_rgba),
   .clr_col    (clr_col)
);

// File: tb/sim_zrop_unit.sv
`timescale 1ns/1ps
module sim_zrop_unit;
   localparam int X_W  = 4;
   localparam int Y_W  = 4;
   localparam int Z_W  = 16;
   localparam int NPIX = 1 << (X_W + Y_W);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           frag_valid = 1'b0;
   logic           frag_ready;
   logic [X_W-1:0] frag_x = '0;
   logic [Y_W-1:0] frag_y = '0;
   logic [Z_W-1:0] frag_z = '0;
   logic [31:0]    frag_rgba = '0;
   logic           frag_blend = 1'b0;
   logic           clear_req = 1'b0;
   logic [31:0]    clear_rgba = '0;
   logic           clear_busy;
   logic [X_W-1:0] look_x = '0;
   logic [Y_W-1:0] look_y = '0;
   logic [Z_W-1:0] look_z;
   logic [31:0]    look_rgba;

   int nchk = 0;
   int nfail = 0;
   int stalls = 0;
   bit done = 0;

   logic [Z_W-1:0] mz [NPIX];
   logic [31:0]    mc [NPIX];

   always #2 clk = ~clk;

   zrop_unit #(.X_W(X_W), .Y_W(Y_W), .Z_W(Z_W)) u0 (
      .clk(clk), .rst_n(rst_n), .frag_valid(frag_valid), .frag_ready(frag_ready),
      .frag_x(frag_x), .frag_y(frag_y), .frag_z(frag_z), .frag_rgba(frag_rgba),
      .frag_blend(frag_blend), .clear_req(clear_req), .clear_rgba(clear_rgba),
      .clear_busy(clear_busy), .look_x(look_x), .look_y(look_y),
      .look_z(look_z), .look_rgba(look_rgba)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] blend_ref(input logic [31:0] s, input logic [31:0] d);
      logic [31:0] r;
      int a;
      a = int'(s[31:24]);
      r[31:24] = s[31:24];
      for (int c = 0; c < 3; c++) begin
         int sv;
         int dv;
         sv = int'(s[8*c +: 8]);
         dv = int'(d[8*c +: 8]);
         r[8*c +: 8] = 8'((a * sv + (255 - a) * dv + 127) / 255);
      end
      return r;
   endfunction

   task automatic model(input int p, input logic [Z_W-1:0] z, input logic [31:0] c, input logic b);
      if (z < mz[p]) begin
         mz[p] = z;
         mc[p] = b ? blend_ref(c, mc[p]) : c;
      end
   endtask

   // called at a falling edge; returns at the falling edge after acceptance
   task automatic send(input int p, input logic [Z_W-1:0] z, input logic [31:0] c, input logic b);
      frag_valid = 1'b1;
      frag_x = X_W'(p);
      frag_y = Y_W'(p >> X_W);
      frag_z = z;
      frag_rgba = c;
      frag_blend = b;
      #1;
      while (!frag_ready) begin
         stalls++;
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      frag_valid = 1'b0;
      model(p, z, c, b);
   endtask

   task automatic look(input int p, output logic [Z_W-1:0] z, output logic [31:0] c);
      look_x = X_W'(p);
      look_y = Y_W'(p >> X_W);
      @(negedge clk);
      z = look_z;
      c = look_rgba;
   endtask

   task automatic verify_all(input string tag);
      logic [Z_W-1:0] z;
      logic [31:0]    c;
      repeat (2) @(negedge clk);
      for (int p = 0; p < NPIX; p++) begin
         look(p, z, c);
         chk(tag, 32'(z), 32'(mz[p]));
         chk(tag, c, mc[p]);
      end
   endtask

   task automatic do_clear(input logic [31:0] col);
      int cnt;
      int rdy_hi;
      repeat (2) @(negedge clk);
      clear_rgba = col;
      clear_req = 1'b1;
      @(negedge clk);
      clear_req = 1'b0;
      clear_rgba = 32'hDEADBEEF;
      cnt = 0;
      rdy_hi = 0;
      while (clear_busy && cnt < 4 * NPIX) begin
         cnt++;
         if (frag_ready) rdy_hi++;
         @(negedge clk);
      end
      chk("R9 busy length", 32'(cnt), 32'(NPIX));
      chk("R9 ready low while busy", 32'(rdy_hi), 32'd0);
      for (int p = 0; p < NPIX; p++) begin
         mz[p] = '1;
         mc[p] = col;
      end
   endtask

   function automatic string tag2(input int p);
      if (p % 3 != 0)                 return "R3 dropped";
      if (p % 4 == 1)                 return "R4 plain";
      if (p == 0 || p == 255)         return "R6 alpha end";
      return "R5 blend";
   endfunction

   task automatic finish_up;
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      logic [Z_W-1:0] z;
      logic [31:0]    c;
      int st;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", 32'(frag_ready), 32'd1);
      chk("R1 busy after reset", 32'(clear_busy), 32'd0);

      do_clear(32'h80402010);
      verify_all("R9/R10 clear contents");

      // pass 1: every pixel, distinct pixels back to back, plain write
      st = stalls;
      for (int p = 0; p < NPIX; p++)
         send(p, Z_W'(p * 97 + 1000),
              {~8'(p), 8'(p) ^ 8'h5A, 8'(p + 3), 8'(p * 5)}, 1'b0);
      chk("R11 no stalls on distinct pixels", 32'(stalls - st), 32'd0);
      verify_all("R2/R4 first pass");

      // pass 2: nearer, equal and farther depths; alpha equals pixel index
      for (int p = 0; p < NPIX; p++) begin
         logic [Z_W-1:0] zz;
         zz = Z_W'(p * 97 + 1000);
         if (p % 3 == 0)      zz = zz - 1'b1;
         else if (p % 3 == 2) zz = zz + 5'd5;
         send(p, zz, {8'(p), 8'(p * 29), 8'(p * 13), 8'(p * 7)}, (p % 4) != 1);
      end
      repeat (2) @(negedge clk);
      for (int p = 0; p < NPIX; p++) begin
         look(p, z, c);
         chk(tag2(p), 32'(z), 32'(mz[p]));
         chk(tag2(p), c, mc[p]);
         if (p % 3 == 0 && p % 4 != 1)
            chk("R7 stored alpha", 32'(c[31:24]), 32'(p));
      end

      // pass 3: three fragments to one pixel in a row
      st = stalls;
      send(90, 16'd50, 32'h80FF2040, 1'b1);
      send(90, 16'd40, 32'h40103080, 1'b1);
      send(90, 16'd30, 32'hC0806020, 1'b1);
      chk("R8 one stall per repeat", 32'(stalls - st), 32'd2);
      repeat (2) @(negedge clk);
      look(90, z, c);
      chk("R8 ordered result z", 32'(z), 32'(mz[90]));
      chk("R8 ordered result colour", c, mc[90]);

      // second clear, then boundary depths
      do_clear(32'h11223344);
      verify_all("R9 second clear");
      send(3, 16'hFFFF, 32'h99999999, 1'b0);
      send(4, 16'hFFFE, 32'h77665544, 1'b0);
      repeat (2) @(negedge clk);
      look(3, z, c);
      chk("R3 max depth dropped z", 32'(z), 32'h0000FFFF);
      chk("R3 max depth dropped colour", c, 32'h11223344);
      look(4, z, c);
      chk("R2 just in front z", 32'(z), 32'h0000FFFE);
      chk("R4 just in front colour", c, 32'h77665544);
      // R6 directly: opaque over, then transparent over
      send(4, 16'h0100, 32'hFF0A0B0C, 1'b1);
      send(5, 16'h0100, 32'h00ABCDEF, 1'b1);
      repeat (2) @(negedge clk);
      look(4, z, c);
      chk("R6 alpha 255 copies source", c, 32'hFF0A0B0C);
      look(5, z, c);
      chk("R6 alpha 0 keeps rgb", c, 32'h00223344);

      finish_up();
   end
endmodule